// File: doc/BRIEF.md
# Serial Management Bus Master

This block runs single register reads and writes on a two-wire management bus. The bus has one clock output and one data line that both sides share. Software controls the block through a single 32-bit command word. It writes the register address, the read/write choice and, for a write, the data. It sets the go bit in the same write, then polls the word until the busy flag drops. After a read, the low half of the word holds the value that came back from the device.

Each transaction is one complete frame, in this order: a preamble of ones, a start pattern, an opcode and a 10-bit register address. Next come two turnaround clocks that the master drives high. A write then sends 16 data bits. A read releases the data pin and takes in 32 bits, of which the first 16 are kept. Every frame ends with four dummy clocks with the data line low. The management clock comes from a counter of system clocks per half period. The data pin changes only while that clock is low.

Top module: `mgmt_bus_master`

## Requirements
- R1: Command word layout: bit 31 is go/busy, bit 30 selects a read when 1 and a write when 0, bits 25:16 hold the address, bits 29:26 read as 0, and bits 15:0 hold write data or returned read data. A write with bit 31 set while idle starts a frame, and bit 31 reads back as 1 from the next cycle.
- R2: Each frame starts with 32 clock periods during which the data line is driven to 1.
- R3: The preamble is followed by the start pattern 0 then 1. The opcode follows that: 1 then 0 for a read, 0 then 1 for a write.
- R4: The 10 address bits follow, most significant first, one per clock period, with the pin driven.
- R5: Two turnaround periods follow the address, with the pin driven to 1.
- R6: On a read the data pin is released (mdio_oe = 0) for 32 clock periods. The line is sampled in the last system cycle of each low phase. Bits 15:0 of the word then return the first 16 bits sampled, with the first sampled bit in bit 15.
- R7: On a write the pin stays driven, and the 16 data bits go out from bit 15 down to bit 0.
- R8: Every frame ends with 4 clock periods with the pin driven to 0, for a total of 68 clock periods per write and 84 per read. Afterwards the clock rests at 0 and the pin is driven at 0.
- R9: The clock high phase and low phase each last HALF_CYC system clocks, and the clock is 0 whenever the block is not busy.
- R10: A write to the command word while busy is 1 has no effect, on the frame or on the stored fields.
- R11: Busy clears in the same cycle that the read result appears in bits 15:0.
- R12: mdio_o and mdio_oe change only in cycles where the management clock is 0.
- R13: Synchronous reset gives clock 0, data pin driven (mdio_oe = 1) at 1, busy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word write value |
| cmd_rdata | output | 32 | Command word read value (busy, read flag, address, data) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (1 = master drives) |
| mdio_i | input | 1 | Data line input value |

## Verification
Write frames go out to a walking-one address with a data word that varies, so that each address and data bit position is seen to move on its own. Read frames use the complementary walking-zero address. The device model answers each read with 32 bits whose two halves differ, including all-ones in the upper half with zeros below and the reverse. These responses show that only the first 16 sampled bits are returned and that they come back in the right order. Each frame is captured bit by bit at the rising clock edges and split into its fields. A command written in the middle of a frame, with a different address and opcode, shows that the frame and the stored fields are left untouched.

// File: rtl/mgmt_bus_pkg.sv
package mgmt_bus_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int GO_BIT   = 31;
  localparam int RD_BIT   = 30;
  localparam int ADDR_LSB = 16;
  localparam int ADDR_MAX = 14;

  typedef struct packed {
    logic                busy;
    logic                is_read;
    logic [ADDR_MAX-1:0] addr;
    logic [DATA_W-1:0]   data;
  } cmd_word_t;
endpackage

// File: rtl/mgmt_clk_gen.sv
module mgmt_clk_gen #(
  parameter int HALF_CYC = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int PERIOD = 2 * HALF_CYC;
  localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] RISE_AT = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0] FALL_AT = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph <= '0;
    end else if (ph == FALL_AT) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign rise_tick = run && (ph == RISE_AT);
  assign fall_tick = run && (ph == FALL_AT);
endmodule

// File: rtl/mgmt_cmd_reg.sv
module mgmt_cmd_reg
  import mgmt_bus_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              seq_done,
  input  logic [DATA_W-1:0] seq_rdata,
  output logic              start,
  output logic              is_read,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic [CMD_W-1:0]  cmd_rdata
);
  logic      busy;
  cmd_word_t word;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      start   <= 1'b0;
      is_read <= 1'b0;
      addr    <= '0;
      data    <= '0;
    end else begin
      start <= 1'b0;
      if (cmd_we && !busy) begin
        is_read <= cmd_wdata[RD_BIT];
        addr    <= cmd_wdata[ADDR_LSB +: ADDR_W];
        data    <= cmd_wdata[DATA_W-1:0];
        if (cmd_wdata[GO_BIT]) begin
          busy  <= 1'b1;
          start <= 1'b1;
        end
      end else if (seq_done) begin
        busy <= 1'b0;
        if (is_read) data <= seq_rdata;
      end
    end
  end

  always_comb begin
    word.busy    = busy;
    word.is_read = is_read;
    word.addr    = ADDR_MAX'(addr);
    word.data    = data;
    cmd_rdata    = word;
  end
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_bus_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PRE_LEN   = 32,
  parameter int RX_W      = 32,
  parameter int DUMMY_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int HDR_LEN = PRE_LEN + 2 + 2 + ADDR_W + 2;
  localparam int SR_W    = HDR_LEN + RX_W + DUMMY_LEN;
  localparam int WR_LEN  = HDR_LEN + DATA_W + DUMMY_LEN;
  localparam int CNT_W   = $clog2(SR_W + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(SR_W - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(HDR_LEN + RX_W);

  logic [HDR_LEN-1:0] hdr;
  logic [SR_W-1:0]    load_vec;
  logic [WR_LEN-1:0]  wr_vec;
  logic [SR_W-1:0]    sr;
  logic [RX_W-1:0]    rx;
  logic [CNT_W-1:0]   idx;
  logic [CNT_W-1:0]   idx_nx;
  logic               rd_mode;
  logic               last_bit;

  always_comb begin
    hdr    = {{PRE_LEN{1'b1}}, 2'b01, (is_read ? 2'b10 : 2'b01), addr, 2'b11};
    wr_vec = {hdr, wdata, {DUMMY_LEN{1'b0}}};
    if (is_read) load_vec = {hdr, {RX_W{1'b1}}, {DUMMY_LEN{1'b0}}};
    else         load_vec = SR_W'(wr_vec) << (SR_W - WR_LEN);
  end

  function automatic logic in_win(input logic [CNT_W-1:0] n);
    return (n >= WIN_LO) && (n < WIN_HI);
  endfunction

  assign idx_nx   = idx + 1'b1;
  assign last_bit = rd_mode ? (idx == RD_LAST) : (idx == WR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      mdc_o   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
      done    <= 1'b0;
      idx     <= '0;
      sr      <= '0;
      rx      <= '0;
      rd_mode <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run     <= 1'b1;
          sr      <= load_vec;
          mdio_o  <= load_vec[SR_W-1];
          mdio_oe <= 1'b1;
          idx     <= '0;
          rd_mode <= is_read;
        end
      end else begin
        if (rise_tick) begin
          mdc_o <= 1'b1;
          if (rd_mode && in_win(idx)) rx <= {rx[RX_W-2:0], mdio_i};
        end
        if (fall_tick) begin
          mdc_o <= 1'b0;
          if (last_bit) begin
            run     <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b1;
            if (rd_mode) rdata <= rx[RX_W-1 -: DATA_W];
          end else begin
            idx     <= idx_nx;
            sr      <= sr << 1;
            mdio_o  <= sr[SR_W-2];
            mdio_oe <= !(rd_mode && in_win(idx_nx));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_bus_pkg::*;
#(
  parameter int HALF_CYC  = 1250,
  parameter int ADDR_W    = 10,
  parameter int PRE_LEN   = 32,
  parameter int RX_W      = 32,
  parameter int DUMMY_LEN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              start;
  logic              is_read;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] seq_rdata;
  logic              seq_done;
  logic              run;
  logic              rise_tick;
  logic              fall_tick;

  mgmt_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .seq_done  (seq_done),
    .seq_rdata (seq_rdata),
    .start     (start),
    .is_read   (is_read),
    .addr      (addr),
    .data      (wdata),
    .cmd_rdata (cmd_rdata)
  );

  mgmt_clk_gen #(.HALF_CYC(HALF_CYC)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mgmt_frame_seq #(
    .ADDR_W    (ADDR_W),
    .PRE_LEN   (PRE_LEN),
    .RX_W      (RX_W),
    .DUMMY_LEN (DUMMY_LEN)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_read   (is_read),
    .addr      (addr),
    .wdata     (wdata),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .run       (run),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (seq_done),
    .rdata     (seq_rdata)
  );
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk #(
  parameter int HALF_CYC = 1250
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_we,
  input logic [31:0] cmd_rdata,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        seq_done
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)        hi_cnt <= '0;
    else if (mdc_o) hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  p_high_len_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(mdc_o) |-> (hi_cnt == 32'(HALF_CYC)));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_rdata[31] |-> !mdc_o);

  p_release_read_r6: assert property (@(posedge clk) disable iff (rst)
    !mdio_oe |-> (cmd_rdata[31] && cmd_rdata[30]));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[31] && cmd_we) |=> $stable(cmd_rdata[30:16]));

  p_done_clear_r11: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !cmd_rdata[31]);

  p_low_change_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable({mdio_o, mdio_oe}) |-> !mdc_o);
endmodule

bind mgmt_bus_master mgmt_bus_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_we    (cmd_we),
  .cmd_rdata (cmd_rdata),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .seq_done  (seq_done)
);

// File: tb/mgmt_bus_master_tb.sv
module mgmt_bus_master_tb;
  localparam int HALF = 4;
  localparam int TCLK = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc_o, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int  rise_cnt = 0;
  int  base = 0;
  logic [31:0] resp = '0;
  logic cap_o  [0:8191];
  logic cap_oe [0:8191];
  time t_rise = 0, t_fall = 0, hi_ns = 0, lo_ns = 0;

  always #(TCLK/2) clk = ~clk;

  mgmt_bus_master #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc_o) begin
    cap_o[rise_cnt % 8192]  = mdio_o;
    cap_oe[rise_cnt % 8192] = mdio_oe;
    rise_cnt = rise_cnt + 1;
    lo_ns  = $time - t_fall;
    t_rise = $time;
  end

  always @(negedge mdc_o) begin
    int c;
    hi_ns  = $time - t_rise;
    t_fall = $time;
    c = rise_cnt - base;
    if (c >= 48 && c < 80) mdio_i = resp[79 - c];
    else                   mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit rd, input logic [9:0] a, input logic [15:0] d,
                         input logic [31:0] r, input bit inject);
    int errs [0:15];
    int n, tmo;
    logic [15:0] exp_data;
    base = rise_cnt;
    resp = r;
    for (int g = 0; g < 16; g++) errs[g] = 0;
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = {1'b1, rd, 4'b0, a, d};
    @(negedge clk);
    cmd_we = 1'b0;
    chk(cmd_rdata[31] == 1'b1, "R1 busy set", cmd_rdata[31], 1);
    chk(cmd_rdata[30:16] == {rd, 4'b0, a}, "R1 fields", cmd_rdata[30:16], {rd, 4'b0, a});
    if (inject) begin
      repeat (100) @(negedge clk);
      cmd_we = 1'b1;
      cmd_wdata = {1'b1, ~rd, 4'hF, ~a, ~d};
      @(negedge clk);
      cmd_we = 1'b0;
    end
    tmo = 0;
    while (cmd_rdata[31] && tmo < 5000) begin
      @(negedge clk);
      tmo++;
    end
    exp_data = rd ? r[31:16] : d;
    chk(!cmd_rdata[31], "R8 frame ends", cmd_rdata[31], 0);
    chk(cmd_rdata[15:0] == exp_data, rd ? "R11 data with busy clear (R6)" : "R7 write data kept",
        cmd_rdata[15:0], exp_data);
    if (inject)
      chk(cmd_rdata[30:16] == {rd, 4'b0, a}, "R10 fields untouched", cmd_rdata[30:16], {rd, 4'b0, a});
    n = rise_cnt - base;
    chk(n == (rd ? 84 : 68), "R8 clock count", n, rd ? 84 : 68);
    for (int k = 0; k < n && k < 84; k++) begin
      bit eo, eoe, odc;
      int grp;
      eoe = 1; odc = 0;
      if (k < 32)      begin eo = 1; grp = 2; end
      else if (k < 34) begin eo = (k == 33); grp = 3; end
      else if (k < 36) begin eo = rd ? (k == 34) : (k == 35); grp = 3; end
      else if (k < 46) begin eo = a[45 - k]; grp = 4; end
      else if (k < 48) begin eo = 1; grp = 5; end
      else if (rd && k < 80)  begin eo = 0; eoe = 0; odc = 1; grp = 6; end
      else if (!rd && k < 64) begin eo = d[63 - k]; grp = 7; end
      else begin eo = 0; grp = 8; end
      if (cap_oe[(base + k) % 8192] !== eoe) errs[grp]++;
      if (!odc && cap_o[(base + k) % 8192] !== eo) errs[grp]++;
    end
    chk(errs[2] == 0, "R2 preamble", errs[2], 0);
    chk(errs[3] == 0, "R3 start/opcode", errs[3], 0);
    chk(errs[4] == 0, "R4 address", errs[4], 0);
    chk(errs[5] == 0, "R5 turnaround", errs[5], 0);
    if (rd) chk(errs[6] == 0, "R6 release", errs[6], 0);
    else    chk(errs[7] == 0, "R7 write bits", errs[7], 0);
    chk(errs[8] == 0, "R8 dummy", errs[8], 0);
    chk(hi_ns == HALF * TCLK, "R9 high phase", int'(hi_ns), HALF * TCLK);
    chk(lo_ns == HALF * TCLK, "R9 low phase", int'(lo_ns), HALF * TCLK);
    repeat (10) begin
      @(negedge clk);
      if (mdc_o || mdio_o || !mdio_oe) break;
    end
    chk(!mdc_o && !mdio_o && mdio_oe, "R8 rest levels (R9)", {mdc_o, mdio_o, mdio_oe}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mdc_o && mdio_o && mdio_oe && !cmd_rdata[31], "R13 reset state",
        {mdc_o, mdio_o, mdio_oe, cmd_rdata[31]}, 4'b0110);
    chk(cmd_rdata == 32'h0, "R1 word after reset", cmd_rdata, 0);
    // R1: a write without the go bit stores fields but starts nothing
    cmd_we = 1'b1; cmd_wdata = 32'h4155_00AA;
    @(negedge clk); cmd_we = 1'b0;
    repeat (4 * HALF) @(negedge clk);
    chk(cmd_rdata == 32'h4155_00AA && !mdc_o, "R1 no go bit", cmd_rdata, 32'h4155_00AA);
    run_txn(0, 10'h000, 16'hFFFF, 32'h0, 0);
    run_txn(1, 10'h3FF, 16'h0, 32'hFFFF_0000, 0);
    run_txn(1, 10'h000, 16'h0, 32'h0000_FFFF, 0);
    for (int i = 0; i < 10; i++) begin
      logic [9:0]  wa = 10'(1 << i);
      logic [15:0] wd = 16'(16'h1 << i) ^ 16'hA5C3;
      logic [31:0] rr = {16'(16'h8000 >> i), 16'(16'hFFFF << i)};
      run_txn(0, wa, wd, 32'h0, 0);
      run_txn(1, ~wa, 16'h0, rr, 0);
    end
    run_txn(0, 10'h155, 16'h3C5A, 32'h0, 1);
    run_txn(1, 10'h2AA, 16'h0, 32'h9E37_0000, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * TCLK);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule